// File: doc/BRIEF.md
# Legacy Shadow Region Access Router

This block sits inside a host bridge. It steers every memory access that falls in the legacy window from 0xC0000 to 0xFFFFF either to system DRAM or to the ROM/bus side. The window is split into segments. Each segment has its own read-enable and write-enable attribute, so reads and writes are steered separately. In a write-only setting, writes fill the DRAM shadow while reads still come from ROM. Firmware uses this to copy ROM contents into DRAM and then switch reads over to the DRAM copy.

Seven byte-wide attribute registers hold two 4-bit segment fields each. They are reached through a simple byte-wide configuration port. Memory requests present a 20-bit address and a write flag. One clock edge later, the block presents registered select and write-strobe signals for the DRAM side and for the ROM/bus side.

Top module: `shadow_attr_decoder`

## Requirements
- R1: After synchronous reset, all seven attribute registers read 0x00, so every access inside the legacy window goes to the ROM/bus side.
- R2: The attribute registers sit at configuration offsets 0x59 to 0x5F. Segment i is held in the register at 0x59 + i/2: bits 3:0 when i is even and bits 7:4 when i is odd. Within a field, bit 0 enables reads and bit 1 enables writes.
- R3: Attribute bits 2, 3, 6 and 7 are not stored and always read back as zero.
- R4: A configuration write to an offset outside 0x59 to 0x5F changes no attribute. A configuration read of such an offset returns 0x00.
- R5: Segment 1 covers 0xF0000 to 0xFFFFF as one 64 KB segment. Segments 2 to 9 cover 0xC0000 to 0xDFFFF in ascending 16 KB steps. Segments 10 to 13 cover 0xE0000 to 0xEFFFF in ascending 16 KB steps. Segment 0 controls no address.
- R6: A read in a segment whose read enable is set asserts dram_sel only.
- R7: A write in a segment whose write enable is set asserts dram_sel and dram_we, and the ROM side stays idle.
- R8: A read in a segment whose read enable is clear asserts rom_sel only. A write in a segment whose write enable is clear asserts rom_sel and rom_we. dram_we is never asserted for either.
- R9: Any access below 0xC0000 goes to DRAM, whatever the attributes hold: dram_sel for reads, and dram_sel with dram_we for writes.
- R10: The routing outputs are registered. They reflect the request present at one rising edge from that edge onward, and they are all low after an edge without a request. cfg_rdata likewise reflects the offset present at the preceding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered configuration read data for cfg_addr |
| mem_valid | input | 1 | Memory request present |
| mem_addr | input | 20 | Memory byte address |
| mem_wr | input | 1 | 1 = write, 0 = read |
| dram_sel | output | 1 | Access routed to DRAM |
| dram_we | output | 1 | DRAM write strobe |
| rom_sel | output | 1 | Access routed to ROM/bus side |
| rom_we | output | 1 | ROM/bus write strobe |

## Verification
Every segment is swept through all four attribute settings. Each setting is probed with a read and a write at both the first and the last byte of the segment. This tells apart a swapped read/write bit, a swapped nibble and an off-by-one segment boundary. The expected routing comes from a shadow copy of the attributes that the bench keeps itself, so a stray write into a neighbouring segment also shows up. Separate patterns cover the following:
- addresses just below the window and deep below it, with every attribute set;
- writes to offsets adjacent to the register block;
- the unmapped field segment 0;
- idle cycles between requests.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int ADDR_W   = 20;
  localparam int CFG_AW   = 8;
  localparam int NUM_REGS = 7;
  localparam int FIELD_W  = 4;
  localparam int NUM_SEGS = NUM_REGS * 2;
  localparam int SEG_W    = $clog2(NUM_SEGS);
  localparam logic [7:0] KEEP_MASK = 8'h33;

  typedef logic [SEG_W-1:0] seg_idx_t;

  typedef struct packed {
    logic we;
    logic re;
  } seg_perm_t;

  typedef enum logic [1:0] {
    TGT_IDLE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_ROM  = 2'd2
  } target_e;
endpackage

// File: rtl/attr_regfile.sv
module attr_regfile
  import shadow_attr_pkg::*;
#(
  parameter int NREG = NUM_REGS,
  parameter int AW   = CFG_AW,
  parameter logic [AW-1:0] BASE = 8'h59
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  output logic [NREG*8-1:0] attr_flat
);
  logic [7:0] regs [NREG];
  logic [7:0] rdata_d;
  logic       in_win;

  always_comb begin
    in_win = 1'b0;
    for (int k = 0; k < NREG; k++)
      if (cfg_addr == AW'(int'(BASE) + k)) in_win = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (cfg_wr) begin
      for (int k = 0; k < NREG; k++)
        if (cfg_addr == AW'(int'(BASE) + k)) regs[k] <= cfg_wdata & KEEP_MASK;
    end
  end

  always_comb begin
    rdata_d = '0;
    for (int k = 0; k < NREG; k++)
      if (cfg_addr == AW'(int'(BASE) + k)) rdata_d = regs[k];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rdata_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign attr_flat[g*8 +: 8] = regs[g];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (attr_flat == '0)); // R1
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !in_win) |=> $stable(attr_flat)); // R4
  AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!in_win) |=> (cfg_rdata == 8'h00)); // R4
  AST_RESERVED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> ((cfg_rdata & ~KEEP_MASK) == 8'h00)); // R3
endmodule

// File: rtl/seg_decode.sv
module seg_decode
  import shadow_attr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output logic          legacy,
  output seg_idx_t      seg_idx
);
  localparam int TOP_LSB   = AW - 4;
  localparam int SUB_LSB   = 14;
  localparam int FIRST_CD  = 2;
  localparam int FIRST_E   = 10;
  localparam int BIOS_SEG  = 1;

  logic [3:0] top_nib;
  assign top_nib = addr[TOP_LSB +: 4];

  always_comb begin
    legacy  = 1'b1;
    seg_idx = '0;
    unique case (top_nib)
      4'hC, 4'hD: seg_idx = SEG_W'(FIRST_CD) + SEG_W'(addr[SUB_LSB +: 3]);
      4'hE:       seg_idx = SEG_W'(FIRST_E) + SEG_W'(addr[SUB_LSB +: 2]);
      4'hF:       seg_idx = SEG_W'(BIOS_SEG);
      default: begin
        legacy  = 1'b0;
        seg_idx = '0;
      end
    endcase
  end
endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
  import shadow_attr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      mem_valid,
  input  logic      mem_wr,
  input  logic      legacy,
  input  seg_perm_t perm,
  output logic      dram_sel,
  output logic      dram_we,
  output logic      rom_sel,
  output logic      rom_we
);
  target_e tgt;
  logic    allow;

  always_comb begin
    allow = mem_wr ? perm.we : perm.re;
    if (!mem_valid)              tgt = TGT_IDLE;
    else if (!legacy || allow)   tgt = TGT_DRAM;
    else                         tgt = TGT_ROM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_sel <= 1'b0;
      dram_we  <= 1'b0;
      rom_sel  <= 1'b0;
      rom_we   <= 1'b0;
    end else begin
      dram_sel <= (tgt == TGT_DRAM);
      dram_we  <= (tgt == TGT_DRAM) && mem_wr;
      rom_sel  <= (tgt == TGT_ROM);
      rom_we   <= (tgt == TGT_ROM) && mem_wr;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    !(dram_sel && rom_sel)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mem_valid) |=> !(dram_sel || rom_sel || dram_we || rom_we)); // R10
  AST_OUTSIDE_DRAM: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !legacy) |=> (dram_sel && (dram_we == $past(mem_wr)))); // R9
  AST_BLOCKED_READ_ROM: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && legacy && !mem_wr && !perm.re) |=> (rom_sel && !dram_sel)); // R8
  AST_BLOCKED_WRITE_NO_DRAM_WE: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && legacy && mem_wr && !perm.we) |=> (rom_we && !dram_we)); // R8
  AST_OPEN_WRITE_DRAM: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && legacy && mem_wr && perm.we) |=> (dram_we && !rom_sel)); // R7
  AST_OPEN_READ_DRAM: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && legacy && !mem_wr && perm.re) |=> (dram_sel && !dram_we)); // R6
endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
  import shadow_attr_pkg::*;
#(
  parameter int AW_MEM = ADDR_W,
  parameter int AW_CFG = CFG_AW,
  parameter logic [AW_CFG-1:0] CFG_BASE = 8'h59
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [AW_CFG-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              mem_valid,
  input  logic [AW_MEM-1:0] mem_addr,
  input  logic              mem_wr,
  output logic              dram_sel,
  output logic              dram_we,
  output logic              rom_sel,
  output logic              rom_we
);
  localparam int FLAT_W = NUM_REGS * 8;

  logic [FLAT_W-1:0] attr_flat;
  logic              legacy;
  seg_idx_t          seg_idx;
  logic [FIELD_W-1:0] field;
  seg_perm_t         perm;

  attr_regfile #(.NREG(NUM_REGS), .AW(AW_CFG), .BASE(CFG_BASE)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .attr_flat(attr_flat)
  );

  seg_decode #(.AW(AW_MEM)) u_dec (
    .addr(mem_addr), .legacy(legacy), .seg_idx(seg_idx)
  );

  // Segment i occupies nibble i of the flat vector: byte i/2, half i%2.
  assign field   = attr_flat[{seg_idx, 2'b00} +: FIELD_W];
  assign perm.re = field[0];
  assign perm.we = field[1];

  route_ctrl u_route (
    .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_wr(mem_wr),
    .legacy(legacy), .perm(perm),
    .dram_sel(dram_sel), .dram_we(dram_we), .rom_sel(rom_sel), .rom_we(rom_we)
  );
endmodule

// File: tb/shadow_attr_decoder_test.sv
`timescale 1ns/1ps
module shadow_attr_decoder_test;
  logic clk = 0;
  logic rst;
  logic cfg_wr;
  logic [7:0] cfg_addr, cfg_wdata, cfg_rdata;
  logic mem_valid, mem_wr;
  logic [19:0] mem_addr;
  logic dram_sel, dram_we, rom_sel, rom_we;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [7];

  always #5 clk = ~clk;

  shadow_attr_decoder uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .dram_sel(dram_sel),
    .dram_we(dram_we), .rom_sel(rom_sel), .rom_we(rom_we)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
    if (a >= 8'h59 && a <= 8'h5F) model[a - 8'h59] = d & 8'h33;
  endtask

  task automatic cfg_read_chk(input logic [7:0] a, input string req);
    logic [7:0] e;
    e = (a >= 8'h59 && a <= 8'h5F) ? model[a - 8'h59] : 8'h00;
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    check(req, cfg_rdata, e);
  endtask

  // Expected routing as {dram_sel, dram_we, rom_sel, rom_we}
  function automatic logic [3:0] expect_route(input int a, input logic wr);
    int s;
    logic [3:0] nib;
    logic ok;
    s = -1;
    if (a >= 'hF0000)      s = 1;
    else if (a >= 'hE0000) s = 10 + (a - 'hE0000) / 16384;
    else if (a >= 'hC0000) s = 2 + (a - 'hC0000) / 16384;
    if (s < 0) return {1'b1, wr, 2'b00};
    nib = (s % 2 == 1) ? model[s/2][7:4] : model[s/2][3:0];
    ok = wr ? nib[1] : nib[0];
    return {ok, ok & wr, ~ok, ~ok & wr};
  endfunction

  task automatic mem_chk(input int a, input logic wr, input string req);
    logic [3:0] e;
    e = expect_route(a, wr);
    @(negedge clk);
    mem_valid = 1; mem_addr = a[19:0]; mem_wr = wr;
    @(negedge clk);
    mem_valid = 0;
    check(req, {dram_sel, dram_we, rom_sel, rom_we}, e);
  endtask

  task automatic set_seg(input int s, input logic [3:0] f);
    logic [7:0] r;
    r = model[s/2];
    if (s % 2 == 1) r[7:4] = f; else r[3:0] = f;
    cfg_write(8'(8'h59 + s/2), r);
  endtask

  task automatic t_reset;  // R1
    for (int k = 0; k < 7; k++) cfg_read_chk(8'(8'h59 + k), "R1 reset reg");
    mem_chk('hC0000, 0, "R1 reset read ROM");
    mem_chk('hFFFFF, 1, "R1 reset write ROM");
  endtask

  task automatic t_idle;  // R10
    @(negedge clk); mem_valid = 0;
    @(negedge clk);
    check("R10 idle outputs", {dram_sel, dram_we, rom_sel, rom_we}, 0);
  endtask

  task automatic t_cfg_map;  // R2 R3 R4
    cfg_write(8'h5C, 8'hFF);
    cfg_read_chk(8'h5C, "R3 reserved bits zero");
    cfg_write(8'h5C, 8'h00);
    cfg_write(8'h58, 8'h33);
    cfg_write(8'h60, 8'h33);
    cfg_write(8'h00, 8'h33);
    for (int k = 0; k < 7; k++) cfg_read_chk(8'(8'h59 + k), "R4 foreign write ignored");
    mem_chk('hCC000, 0, "R4 routing unchanged");
    cfg_read_chk(8'h58, "R4 foreign read zero");
    cfg_read_chk(8'h60, "R4 foreign read zero");
    cfg_write(8'h59, 8'h03);  // segment 0 only
    mem_chk('hC0000, 0, "R5 segment 0 unmapped");
    mem_chk('hF0000, 1, "R5 segment 0 unmapped");
    cfg_write(8'h59, 8'h00);
    cfg_write(8'h5A, 8'h21);  // seg 2 RE, seg 3 WE
    cfg_read_chk(8'h5A, "R2 readback");
    mem_chk('hC0000, 0, "R2 even low nibble read");
    mem_chk('hC4000, 1, "R2 odd high nibble write");
    mem_chk('hC4000, 0, "R2 odd high nibble read");
    cfg_write(8'h5A, 8'h00);
  endtask

  task automatic t_sweep;  // R5 R6 R7 R8
    int lo, hi;
    for (int s = 1; s < 14; s++) begin
      if (s == 1) begin lo = 'hF0000; hi = 'hFFFFF; end
      else if (s < 10) begin lo = 'hC0000 + (s-2)*16384; hi = lo + 16383; end
      else begin lo = 'hE0000 + (s-10)*16384; hi = lo + 16383; end
      for (int m = 0; m < 4; m++) begin
        set_seg(s, 4'(m));
        mem_chk(lo, 0, "R6 R8 R5 read low edge");
        mem_chk(hi, 0, "R6 R8 R5 read high edge");
        mem_chk(lo, 1, "R7 R8 R5 write low edge");
        mem_chk(hi, 1, "R7 R8 R5 write high edge");
      end
      set_seg(s, 4'h2);  // leave write-only to expose neighbour leakage
    end
  endtask

  task automatic t_outside;  // R9
    for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h00);
    mem_chk('hBFFFF, 0, "R9 below window read");
    mem_chk('hBFFFF, 1, "R9 below window write");
    mem_chk('h00000, 1, "R9 low write");
    for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h33);
    mem_chk('h12345, 0, "R9 read with attrs set");
    mem_chk('hA0000, 1, "R9 write with attrs set");
  endtask

  initial begin
    for (int k = 0; k < 7; k++) model[k] = 8'h00;
    rst = 1; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0;
    mem_valid = 0; mem_addr = 0; mem_wr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_idle();
    t_cfg_map();
    t_sweep();
    t_idle();
    t_outside();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule